// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block sits on the host side of a 12-bit successive-approximation converter that has a serial result port. It opens each conversion by pulling the conversion-start line low for a short programmable width and then releasing it. The rising edge is the instant the converter's track/hold stops tracking and starts holding. The sequencer then waits out the conversion time. After that it generates a serial clock, shifts in the 12 result bits MSB first, and presents the result as one strobed word. The word is widened to 16 bits, with sign extension for a bipolar input range (two's complement code) or zero extension for a unipolar one (straight binary code).

The block works in two modes. In continuous mode a period counter schedules conversion starts a fixed number of system clock cycles apart, as set by the sample-period input. In single-shot mode, a start pulse given while the block is idle runs exactly one conversion. Every interval is a clock-cycle count derived at elaboration from the clock frequency and the converter's time limits. These limits are a 6 µs conversion, a 600 ns read-free guard before the next start, and a 1.5 µs acquisition window. The sequencer always leaves the guard interval quiet after each read. If the requested period is too short to fit a whole conversion cycle, the sequencer flags an error and runs at the shortest legal period instead.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `convst` is high, `sclk` is low, `res_valid` is low, and `period_err` is low when the requested period is legal.
- R2: A conversion begins with `convst` driven low for exactly CS_LOW_CYC cycles (default 2) and then driven high. `sclk` is never high while `convst` is low. With `run_en` low, a `start_once` pulse while idle runs exactly one conversion. A `start_once` pulse while a conversion is in progress is ignored.
- R3: The first `sclk` rising edge of a read comes exactly CONV_CYC cycles after the `convst` rising edge (6 µs rounded up, 300 cycles at 50 MHz). There is no `sclk` activity earlier.
- R4: A read is exactly 12 `sclk` pulses, each high for HALF_CYC cycles and then low for HALF_CYC cycles. `sdata` is sampled at each `sclk` rising edge, MSB first. The converter presents the MSB before the first pulse and moves to the next bit on each falling edge.
- R5: `res_valid` is a single-cycle strobe asserted HALF_CYC+1 cycles after the last `sclk` falling edge.
- R6: When `bipolar` was high at the conversion start, `res_bipolar` is 1 and `res_data` is the 12-bit two's complement code sign-extended to 16 bits (code 0x800 gives 0xF800, code 0x7FF gives 0x07FF).
- R7: When `bipolar` was low at the conversion start, `res_bipolar` is 0 and `res_data` is the straight binary code zero-extended (code 0xFFF gives 0x0FFF).
- R8: With `run_en` high, successive `convst` falling edges are exactly max(`period_cyc`, MIN_PERIOD) cycles apart. MIN_PERIOD = CS_LOW_CYC + CONV_CYC + (2·12·HALF_CYC + 1) + GUARD_CYC + 1, which is 382 with the defaults.
- R9: `period_err` equals (`period_cyc` < MIN_PERIOD), registered one cycle later.
- R10: Between the last `sclk` falling edge of a read and the next `convst` falling edge there are more than GUARD_CYC cycles (600 ns rounded up, 30 cycles at 50 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Continuous sampling enable |
| start_once | input | 1 | Single-conversion request, honoured when idle and `run_en` is low |
| bipolar | input | 1 | Range type for the next conversion: 1 = two's complement, 0 = straight binary |
| period_cyc | input | 16 | Requested sample period in clock cycles |
| convst | output | 1 | Conversion start to the converter; idle high, conversion starts on its rising edge |
| sclk | output | 1 | Serial read clock to the converter, idle low |
| sdata | input | 1 | Serial result bit from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_bipolar | output | 1 | Format of the strobed result |
| res_data | output | 16 | Extended conversion result |
| period_err | output | 1 | Requested period is below the minimum and is being clamped |

## Verification
A wrong phase counter or state in the sequencer shows up in the next conversion at the latest. It appears as a low pulse of the wrong width, a read clock that starts before or after the CONV_CYC mark, or a start edge that arrives with the guard interval not yet clear. Each of these is visible at the pins within one sample period. A fault in the shift or bit-count logic gives a wrong bit count or a wrong word at the very next `res_valid`. A fault in the period counter or the clamp shows as a spacing between successive `convst` falling edges other than max(`period_cyc`, MIN_PERIOD). Random codes and range types mixed with the extreme codes expose extension faults in one strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_CONV,
      ST_READ,
      ST_QUIET
   } seq_state_t;

   // Round a time in ns up to whole clock cycles.
   function automatic int ns_to_cyc(input int t_ns, input int clk_mhz);
      return (t_ns * clk_mhz + 999) / 1000;
   endfunction

endpackage

// File: rtl/adc_rate_gen.sv
module adc_rate_gen #(
   parameter int PER_W      = 16,
   parameter int MIN_PERIOD = 382
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [PER_W-1:0] period_cyc,
   output logic             tick,
   output logic             period_err
);
   localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PERIOD);

   logic [PER_W-1:0] cnt;
   logic [PER_W-1:0] eff_period;
   logic             too_short;

   assign too_short  = (period_cyc < MIN_P);
   assign eff_period = too_short ? MIN_P : period_cyc;
   assign tick       = run_en && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         period_err <= 1'b0;
      end else begin
         period_err <= too_short;
         if (!run_en)
            cnt <= '0;
         else if (tick)
            cnt <= eff_period - PER_W'(1);
         else
            cnt <= cnt - PER_W'(1);
      end
   end
endmodule

// File: rtl/adc_serial_rx.sv
module adc_serial_rx #(
   parameter int DATA_W   = 12,
   parameter int HALF_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sdata,
   output logic              sclk,
   output logic              done,
   output logic [DATA_W-1:0] data
);
   localparam int HW = $clog2(HALF_CYC + 1);
   localparam int BW = $clog2(DATA_W + 1);

   logic          busy;
   logic [HW-1:0] hcnt;
   logic [BW-1:0] nbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sclk  <= 1'b0;
         done  <= 1'b0;
         hcnt  <= '0;
         nbits <= '0;
         data  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy  <= 1'b1;
            sclk  <= 1'b1;
            data  <= {data[DATA_W-2:0], sdata};
            nbits <= BW'(1);
            hcnt  <= HW'(HALF_CYC - 1);
         end else if (busy) begin
            if (hcnt != '0) begin
               hcnt <= hcnt - HW'(1);
            end else if (sclk) begin
               sclk <= 1'b0;
               hcnt <= HW'(HALF_CYC - 1);
            end else if (nbits == BW'(DATA_W)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               sclk  <= 1'b1;
               data  <= {data[DATA_W-2:0], sdata};
               nbits <= nbits + BW'(1);
               hcnt  <= HW'(HALF_CYC - 1);
            end
         end
      end
   end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
   parameter int DATA_W = 12,
   parameter int OUT_W  = 16
) (
   input  logic [DATA_W-1:0] raw,
   input  logic              bipolar,
   output logic [OUT_W-1:0]  word
);
   generate
      if (OUT_W > DATA_W) begin : g_extend
         localparam int PAD = OUT_W - DATA_W;
         logic [PAD-1:0] fill;
         assign fill = bipolar ? {PAD{raw[DATA_W-1]}} : '0;
         assign word = {fill, raw};
      end else begin : g_same
         assign word = raw;
      end
   endgenerate
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_seq_pkg::*;
#(
   parameter int CLK_MHZ    = 50,
   parameter int CONV_NS    = 6000,
   parameter int GUARD_NS   = 600,
   parameter int ACQ_NS     = 1500,
   parameter int CS_LOW_CYC = 2,
   parameter int HALF_CYC   = 2,
   parameter int DATA_W     = 12,
   parameter int OUT_W      = 16,
   parameter int PER_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             start_once,
   input  logic             bipolar,
   input  logic [PER_W-1:0] period_cyc,
   output logic             convst,
   output logic             sclk,
   input  logic             sdata,
   output logic             res_valid,
   output logic             res_bipolar,
   output logic [OUT_W-1:0] res_data,
   output logic             period_err
);
   localparam int CONV_CYC   = ns_to_cyc(CONV_NS, CLK_MHZ);
   localparam int GUARD_CYC  = ns_to_cyc(GUARD_NS, CLK_MHZ);
   localparam int ACQ_CYC    = ns_to_cyc(ACQ_NS, CLK_MHZ);
   localparam int READ_CYC   = 2 * DATA_W * HALF_CYC + 1;
   localparam int MIN_PERIOD = CS_LOW_CYC + CONV_CYC + READ_CYC + GUARD_CYC + 1;
   localparam int CNT_MAX    = (CONV_CYC > GUARD_CYC) ?
                               ((CONV_CYC > CS_LOW_CYC) ? CONV_CYC : CS_LOW_CYC) :
                               ((GUARD_CYC > CS_LOW_CYC) ? GUARD_CYC : CS_LOW_CYC);
   localparam int CNT_W      = $clog2(CNT_MAX + 1);

   // Elaboration-time parameter checks
   if (CS_LOW_CYC < 1 || HALF_CYC < 1 || CONV_CYC < 1 || GUARD_CYC < 1) begin : g_bad_len
      $error("adc_conv_seq: every interval must be at least one cycle");
   end
   if (DATA_W < 2 || OUT_W < DATA_W) begin : g_bad_width
      $error("adc_conv_seq: OUT_W must be at least DATA_W, DATA_W at least 2");
   end
   if (READ_CYC + GUARD_CYC + CS_LOW_CYC + 1 < ACQ_CYC) begin : g_bad_acq
      $error("adc_conv_seq: schedule leaves less than the acquisition time");
   end
   if (MIN_PERIOD >= (1 << PER_W)) begin : g_bad_per
      $error("adc_conv_seq: minimum period does not fit PER_W");
   end

   seq_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic              convst_q;
   logic              bip_q;
   logic              tick;
   logic              go;
   logic              rx_start;
   logic              rx_done;
   logic [DATA_W-1:0] rx_data;
   logic [OUT_W-1:0]  fmt_word;

   adc_rate_gen #(
      .PER_W      (PER_W),
      .MIN_PERIOD (MIN_PERIOD)
   ) rate_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .period_cyc (period_cyc),
      .tick       (tick),
      .period_err (period_err)
   );

   adc_serial_rx #(
      .DATA_W   (DATA_W),
      .HALF_CYC (HALF_CYC)
   ) rx_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rx_start),
      .sdata (sdata),
      .sclk  (sclk),
      .done  (rx_done),
      .data  (rx_data)
   );

   adc_result_fmt #(
      .DATA_W (DATA_W),
      .OUT_W  (OUT_W)
   ) fmt_i (
      .raw     (rx_data),
      .bipolar (bip_q),
      .word    (fmt_word)
   );

   assign go       = tick || (start_once && !run_en);
   assign rx_start = (state == ST_CONV) && (cnt == '0);
   assign convst   = convst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         convst_q    <= 1'b1;
         bip_q       <= 1'b0;
         res_valid   <= 1'b0;
         res_bipolar <= 1'b0;
         res_data    <= '0;
      end else begin
         res_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  state    <= ST_LOW;
                  cnt      <= CNT_W'(CS_LOW_CYC - 1);
                  convst_q <= 1'b0;
                  bip_q    <= bipolar;
               end
            end
            ST_LOW: begin
               if (cnt == '0) begin
                  state    <= ST_CONV;
                  convst_q <= 1'b1;
                  cnt      <= CNT_W'(CONV_CYC - 1);
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_CONV: begin
               if (cnt == '0)
                  state <= ST_READ;
               else
                  cnt <= cnt - CNT_W'(1);
            end
            ST_READ: begin
               if (rx_done) begin
                  state       <= ST_QUIET;
                  cnt         <= CNT_W'(GUARD_CYC - 1);
                  res_valid   <= 1'b1;
                  res_data    <= fmt_word;
                  res_bipolar <= bip_q;
               end
            end
            ST_QUIET: begin
               if (cnt == '0)
                  state <= ST_IDLE;
               else
                  cnt <= cnt - CNT_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
   parameter int CONV_CYC   = 300,
   parameter int GUARD_CYC  = 30,
   parameter int MIN_PERIOD = 382,
   parameter int DATA_W     = 12,
   parameter int OUT_W      = 16,
   parameter int PER_W      = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PER_W-1:0] period_cyc,
   input logic             convst,
   input logic             sclk,
   input logic             res_valid,
   input logic             res_bipolar,
   input logic [OUT_W-1:0] res_data,
   input logic             period_err
);
   localparam int PAD = OUT_W - DATA_W;

   int unsigned since_rise;
   int unsigned since_sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rise <= CONV_CYC;
         since_sck  <= GUARD_CYC + 1;
      end else begin
         if (!convst)
            since_rise <= 0;
         else if (since_rise < CONV_CYC)
            since_rise <= since_rise + 1;
         if (sclk)
            since_sck <= 0;
         else if (since_sck <= GUARD_CYC)
            since_sck <= since_sck + 1;
      end
   end

   assert_no_sclk_in_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !convst |-> !sclk);

   assert_conv_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> since_rise >= CONV_CYC);

   assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_sign_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_bipolar) |->
         (res_data[OUT_W-1:DATA_W] == {PAD{res_data[DATA_W-1]}}));

   assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_bipolar) |-> (res_data[OUT_W-1:DATA_W] == '0));

   assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (period_err == ($past(period_cyc) < PER_W'(MIN_PERIOD))));

   assert_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(convst) |-> since_sck > GUARD_CYC);
endmodule

bind adc_conv_seq adc_conv_seq_chk #(
   .CONV_CYC   (CONV_CYC),
   .GUARD_CYC  (GUARD_CYC),
   .MIN_PERIOD (MIN_PERIOD),
   .DATA_W     (DATA_W),
   .OUT_W      (OUT_W),
   .PER_W      (PER_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .period_cyc  (period_cyc),
   .convst      (convst),
   .sclk        (sclk),
   .res_valid   (res_valid),
   .res_bipolar (res_bipolar),
   .res_data    (res_data),
   .period_err  (period_err)
);

// File: tb/adc_conv_seq_tb_top.sv
`timescale 1ns/1ps
module adc_conv_seq_tb_top;
   // Expected timing, computed from the requirements at 50 MHz
   localparam int CS_LOW = 2;
   localparam int HALF   = 2;
   localparam int CONV   = 300;
   localparam int GUARD  = 30;
   localparam int MINP   = CS_LOW + CONV + (2 * 12 * HALF + 1) + GUARD + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        start_once = 1'b0;
   logic        bipolar = 1'b0;
   logic [15:0] period_cyc = 16'd1000;
   logic        convst;
   logic        sclk;
   logic        sdata;
   logic        res_valid;
   logic        res_bipolar;
   logic [15:0] res_data;
   logic        period_err;

   always #10 clk = ~clk;

   adc_conv_seq dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .start_once  (start_once),
      .bipolar     (bipolar),
      .period_cyc  (period_cyc),
      .convst      (convst),
      .sclk        (sclk),
      .sdata       (sdata),
      .res_valid   (res_valid),
      .res_bipolar (res_bipolar),
      .res_data    (res_data),
      .period_err  (period_err)
   );

   // Converter model: holds code at the start edge, shifts on falling sclk
   logic [11:0] adc_code = 12'h000;
   logic [11:0] sr = 12'h000;
   logic [11:0] lat_code = 12'h000;
   logic        lat_bip = 1'b0;
   assign sdata = sr[11];

   always @(posedge convst) begin
      sr       = adc_code;
      lat_code = adc_code;
      lat_bip  = bipolar;
   end
   always @(negedge sclk) sr = {sr[10:0], 1'b0};

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_fmt(input logic [11:0] c, input logic b);
      return b ? {{4{c[11]}}, c} : {4'h0, c};
   endfunction

   function automatic int exp_gap(input int p);
      return (p < MINP) ? MINP : p;
   endfunction

   // Port monitor, sampled on the falling clock edge
   int cyc = 0, fall_cnt = 0, last_fall = 0, last_gap = 0, low_start = 0;
   int rise_cyc = 0, nbits = 0, last_sck_rise = 0, last_sck_fall = 0, valid_cnt = 0;
   bit seen_sck = 0, sck_pending = 0;
   logic prev_cv = 1'b1, prev_sck = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (prev_cv && !convst) begin
            if (fall_cnt > 0) last_gap = cyc - last_fall;
            last_fall = cyc;
            fall_cnt++;
            low_start = cyc;
            if (seen_sck) chk(cyc - last_sck_fall > GUARD, "R10 guard", cyc - last_sck_fall, GUARD + 1);
         end
         if (!prev_cv && convst) begin
            chk(cyc - low_start == CS_LOW, "R2 low width", cyc - low_start, CS_LOW);
            rise_cyc = cyc;
            nbits = 0;
            sck_pending = 1;
         end
         if (!prev_sck && sclk) begin
            if (sck_pending) chk(cyc - rise_cyc == CONV, "R3 conversion wait", cyc - rise_cyc, CONV);
            sck_pending = 0;
            nbits++;
            last_sck_rise = cyc;
         end
         if (prev_sck && !sclk) begin
            chk(cyc - last_sck_rise == HALF, "R4 sclk high width", cyc - last_sck_rise, HALF);
            last_sck_fall = cyc;
            seen_sck = 1;
         end
         if (res_valid) begin
            valid_cnt++;
            chk(nbits == 12, "R4 bit count", nbits, 12);
            chk(cyc - last_sck_fall == HALF + 1, "R5 strobe timing", cyc - last_sck_fall, HALF + 1);
            chk(res_bipolar == lat_bip, lat_bip ? "R6 flag" : "R7 flag", res_bipolar, lat_bip);
            chk(res_data == exp_fmt(lat_code, lat_bip), lat_bip ? "R6 data" : "R7 data",
                res_data, exp_fmt(lat_code, lat_bip));
         end
      end
      prev_cv  = convst;
      prev_sck = sclk;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic single(input logic [11:0] code, input logic bip);
      int v0;
      v0 = valid_cnt;
      adc_code   = code;
      bipolar    = bip;
      start_once = 1'b1;
      wait_cyc(1);
      start_once = 1'b0;
      while (valid_cnt == v0) wait_cyc(1);
      wait_cyc(GUARD + 5);
   endtask

   task automatic run_cont(input int p, input int n);
      int f0;
      period_cyc = 16'(p);
      f0 = fall_cnt;
      run_en = 1'b1;
      while (fall_cnt < f0 + n) begin
         wait_cyc(1);
         if (res_valid) begin
            adc_code = 12'($urandom);
            bipolar  = 1'($urandom);
         end
      end
      chk(last_gap == exp_gap(p), "R8 start spacing", last_gap, exp_gap(p));
      chk(period_err == (p < MINP), "R9 error flag", period_err, p < MINP);
      run_en = 1'b0;
      wait_cyc(2 * MINP);
   endtask

   bit done = 0;

   initial begin
      void'($urandom(32'd7321));
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(3);
      chk(convst == 1'b1, "R1 convst idle", convst, 1);
      chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
      chk(res_valid == 1'b0, "R1 no strobe", res_valid, 0);
      chk(period_err == 1'b0, "R1 no error", period_err, 0);

      // Directed extreme codes for both codings
      single(12'h800, 1'b1);
      single(12'h7FF, 1'b1);
      single(12'h000, 1'b1);
      single(12'hFFF, 1'b1);
      single(12'hFFF, 1'b0);
      single(12'h000, 1'b0);
      single(12'h800, 1'b0);
      single(12'hA5C, 1'b0);

      // R2: starts during a conversion are ignored
      begin
         int v0, f0;
         v0 = valid_cnt;
         f0 = fall_cnt;
         start_once = 1'b1; wait_cyc(1); start_once = 1'b0;
         wait_cyc(20);
         start_once = 1'b1; wait_cyc(1); start_once = 1'b0;
         wait_cyc(150);
         start_once = 1'b1; wait_cyc(1); start_once = 1'b0;
         wait_cyc(2 * MINP);
         chk(valid_cnt == v0 + 1, "R2 busy start ignored (results)", valid_cnt - v0, 1);
         chk(fall_cnt == f0 + 1, "R2 busy start ignored (starts)", fall_cnt - f0, 1);
      end

      // R9: flag follows the requested period one cycle later
      period_cyc = 16'd100;
      wait_cyc(1);
      chk(period_err == 1'b1, "R9 short period flagged", period_err, 1);
      period_cyc = 16'(MINP);
      wait_cyc(1);
      chk(period_err == 1'b0, "R9 minimum period legal", period_err, 0);

      // R8: continuous spacing, directed then random periods
      run_cont(500, 4);
      run_cont(100, 4);
      run_cont(MINP, 4);
      run_cont(MINP - 1, 4);
      run_cont(MINP + 1, 4);
      for (int i = 0; i < 8; i++) run_cont(MINP - 60 + int'($urandom % 240), 5);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule